// File: doc/BRIEF.md
# Header CRC-16 Generator and Checker

This block produces and checks the 16-bit frame check sequence that guards the header of a spread-spectrum packet. It works one bit at a time, in the order the bits go out on the air, and ahead of any scrambling. At the start of each header a start strobe presets the remainder register to all ones. Each protected header bit then steps the register through the polynomial x^16 + x^12 + x^5 + 1.

When the caller raises the checksum-phase input, the block stops folding in data and moves on to the checksum field. In transmit direction it shifts the remainder out most significant bit first, inverted, on a serial output. It also latches the ones-complemented value as a 16-bit status word, which stays readable until the next transmitted header.

In receive direction the caller feeds the received checksum bits during the same phase. The block compares each one against the bit it would have sent. In the cycle after the 16th checksum bit it raises a done pulse together with an error flag. A configuration input chooses whether an error also raises a drop-link request, which sends the receiver back to acquisition, or whether demodulation simply continues.

Top module: `hdr_crc16`

## Requirements
- R1: While reset is asserted and after it is released, done_o, crc_err_o, drop_o and fcs_vld_o are low and crc_status_o reads 0x0000.
- R2: The remainder is preset to 0xFFFF by start_i and stepped per header bit with the polynomial 0x1021 (feedback = remainder bit 15 XOR input bit). The sent checksum is the ones-complement of the remainder, so the ASCII string "123456789", fed each byte MSB first, yields 0xD64E.
- R3: In transmit direction (dir_tx_i = 1), each accepted checksum-phase cycle raises fcs_vld_o. fcs_bit_o then carries the next bit of the complemented remainder, starting with bit 15.
- R4: crc_status_o takes the complemented remainder when the first checksum bit of a transmit frame is accepted. It holds that value through later receive frames until the next transmit frame.
- R5: In receive direction, crc_err_o is high in the done cycle exactly when at least one of the 16 received checksum bits differs from the locally computed complemented remainder.
- R6: done_o is a single-cycle pulse in the cycle after the 16th checksum bit is accepted.
- R7: drop_o equals crc_err_o when drop_on_err_i is 1. When drop_on_err_i is 0, drop_o stays low even on an error.
- R8: After 16 checksum bits, any further valid bit is ignored until the next start_i: fcs_vld_o stays low and no further done_o pulse appears.
- R9: start_i takes priority over a bit offered in the same cycle. In particular, start_i together with the 16th checksum bit produces no done_o pulse and begins a fresh header from 0xFFFF.
- R10: Cycles with bit_vld_i low leave the computation unchanged, so idle gaps between bits do not alter the checksum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Preset remainder and restart the frame |
| dir_tx_i | input | 1 | 1 = transmit (generate), 0 = receive (check) |
| drop_on_err_i | input | 1 | 1 = request link drop on checksum error |
| bit_vld_i | input | 1 | Serial bit strobe |
| bit_i | input | 1 | Serial header or received checksum bit |
| fcs_phase_i | input | 1 | 1 = current bit belongs to the checksum field |
| fcs_bit_o | output | 1 | Serial checksum bit (transmit) |
| fcs_vld_o | output | 1 | fcs_bit_o is being sent this cycle |
| crc_status_o | output | 16 | Checksum of the most recently transmitted header |
| done_o | output | 1 | Checksum field complete (one-cycle pulse) |
| crc_err_o | output | 1 | Received checksum mismatch, valid with done_o |
| drop_o | output | 1 | Return-to-acquisition request |

## Verification
The restart strobe and the completion of the checksum field can land in the same cycle. Only one of them can win, and the restart must. The bench provokes this by driving start_i together with the 16th checksum bit of a transmit frame. It then checks that no done pulse follows. Finally it sends the known "123456789" header without any new start, and the resulting status of 0xD64E shows that the remainder was preset and the bit counter cleared.

// File: rtl/hdr_crc_pkg.sv
package hdr_crc_pkg;
  localparam int          CRC_W    = 16;
  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_INIT = 16'hFFFF;
endpackage

// File: rtl/hdr_crc_step.sv
// One bit-serial step of the remainder update.
module hdr_crc_step #(
  parameter int           W    = hdr_crc_pkg::CRC_W,
  parameter logic [W-1:0] POLY = hdr_crc_pkg::CRC_POLY
) (
  input  logic [W-1:0] rem_i,
  input  logic         bit_i,
  output logic [W-1:0] rem_o
);
  logic fb;

  always_comb begin
    fb    = rem_i[W-1] ^ bit_i;
    rem_o = {rem_i[W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end
endmodule

// File: rtl/hdr_crc_seq.sv
// Phase sequencing: acceptance, checksum bit counter, done/error/drop flags.
module hdr_crc_seq #(
  parameter int W = hdr_crc_pkg::CRC_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic dir_tx_i,
  input  logic drop_on_err_i,
  input  logic bit_vld_i,
  input  logic bit_i,
  input  logic fcs_phase_i,
  input  logic exp_bit_i,
  output logic hdr_acc_o,
  output logic fcs_acc_o,
  output logic first_fcs_o,
  output logic done_o,
  output logic err_o,
  output logic drop_o
);
  localparam int CW = $clog2(W + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          fin_q, fin_d;
  logic          mis_q, mis_d;
  logic          done_d, err_d, drop_d;
  logic          last, cur_mis;

  always_comb begin
    hdr_acc_o   = bit_vld_i & ~fcs_phase_i & ~fin_q & ~start_i;
    fcs_acc_o   = bit_vld_i &  fcs_phase_i & ~fin_q & ~start_i;
    first_fcs_o = fcs_acc_o & (cnt_q == '0);
    last        = fcs_acc_o & (cnt_q == CW'(W - 1));
    cur_mis     = fcs_acc_o & ~dir_tx_i & (bit_i != exp_bit_i);

    cnt_d  = cnt_q;
    fin_d  = fin_q;
    mis_d  = mis_q;
    if (start_i) begin
      cnt_d = '0;
      fin_d = 1'b0;
      mis_d = 1'b0;
    end else begin
      if (fcs_acc_o) cnt_d = cnt_q + 1'b1;
      if (last)      fin_d = 1'b1;
      if (cur_mis)   mis_d = 1'b1;
    end
    done_d = last;
    err_d  = last & ~dir_tx_i & (mis_q | cur_mis);
    drop_d = err_d & drop_on_err_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      fin_q  <= 1'b0;
      mis_q  <= 1'b0;
      done_o <= 1'b0;
      err_o  <= 1'b0;
      drop_o <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      fin_q  <= fin_d;
      mis_q  <= mis_d;
      done_o <= done_d;
      err_o  <= err_d;
      drop_o <= drop_d;
    end
  end

  // R6: done is a single-cycle pulse
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R5: an error is only reported together with done
  a_r5_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done_o);
  // R7: drop requires an error
  a_r7_drop_needs_err: assert property (@(posedge clk) disable iff (!rst_n)
    drop_o |-> err_o);
  // R8: no checksum bit is accepted once the field has completed
  a_r8_no_accept_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !fcs_acc_o);
  // R9: a start suppresses the completion pulse
  a_r9_start_wins: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !done_o);
endmodule

// File: rtl/hdr_crc16.sv
module hdr_crc16 #(
  parameter int           W    = hdr_crc_pkg::CRC_W,
  parameter logic [W-1:0] POLY = hdr_crc_pkg::CRC_POLY,
  parameter logic [W-1:0] INIT = hdr_crc_pkg::CRC_INIT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         dir_tx_i,
  input  logic         drop_on_err_i,
  input  logic         bit_vld_i,
  input  logic         bit_i,
  input  logic         fcs_phase_i,
  output logic         fcs_bit_o,
  output logic         fcs_vld_o,
  output logic [W-1:0] crc_status_o,
  output logic         done_o,
  output logic         crc_err_o,
  output logic         drop_o
);
  logic [W-1:0] rem_q, rem_d, rem_step;
  logic [W-1:0] stat_d;
  logic         hdr_acc, fcs_acc, first_fcs;
  logic         stat_ld;

  hdr_crc_step #(.W(W), .POLY(POLY)) u_step (
    .rem_i (rem_q),
    .bit_i (bit_i),
    .rem_o (rem_step)
  );

  hdr_crc_seq #(.W(W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .dir_tx_i      (dir_tx_i),
    .drop_on_err_i (drop_on_err_i),
    .bit_vld_i     (bit_vld_i),
    .bit_i         (bit_i),
    .fcs_phase_i   (fcs_phase_i),
    .exp_bit_i     (fcs_bit_o),
    .hdr_acc_o     (hdr_acc),
    .fcs_acc_o     (fcs_acc),
    .first_fcs_o   (first_fcs),
    .done_o        (done_o),
    .err_o         (crc_err_o),
    .drop_o        (drop_o)
  );

  always_comb begin
    fcs_bit_o = ~rem_q[W-1];
    fcs_vld_o = fcs_acc & dir_tx_i;
    stat_ld   = first_fcs & dir_tx_i;

    rem_d = rem_q;
    if (start_i)      rem_d = INIT;
    else if (hdr_acc) rem_d = rem_step;
    else if (fcs_acc) rem_d = {rem_q[W-2:0], 1'b0};

    stat_d = stat_ld ? ~rem_q : crc_status_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q        <= INIT;
      crc_status_o <= '0;
    end else begin
      rem_q        <= rem_d;
      crc_status_o <= stat_d;
    end
  end

  // R2: start presets the remainder
  a_r2_preset: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> rem_q == INIT);
  // R3: serial checksum output only in transmit direction
  a_r3_vld_tx_only: assert property (@(posedge clk) disable iff (!rst_n)
    fcs_vld_o |-> dir_tx_i);
  // R4: status only changes on the first transmitted checksum bit
  a_r4_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_ld |=> $stable(crc_status_o));
endmodule

// File: tb/hdr_crc16_bench.sv
`timescale 1ns/1ps
module hdr_crc16_bench;
  typedef struct packed {
    logic [47:0] hdr;
    logic [6:0]  nbits;
    logic        tx;
    logic [15:0] flip;
    logic        drop_en;
    logic        gaps;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{48'h0000_0000_0000, 7'd8,  1'b1, 16'h0000, 1'b0, 1'b0},
    '{48'h0000_00A5_1234, 7'd24, 1'b1, 16'h0000, 1'b0, 1'b1},
    '{48'h0000_F0E1_D2C3, 7'd32, 1'b0, 16'h0000, 1'b1, 1'b0},
    '{48'h0000_F0E1_D2C3, 7'd32, 1'b0, 16'h0001, 1'b1, 1'b1},
    '{48'hABCD_EF01_2345, 7'd48, 1'b0, 16'h8000, 1'b0, 1'b0},
    '{48'h0000_0000_0001, 7'd1,  1'b1, 16'h0000, 1'b0, 1'b1}
  };

  logic        clk, rst_n;
  logic        start_i, dir_tx_i, drop_on_err_i, bit_vld_i, bit_i, fcs_phase_i;
  logic        fcs_bit_o, fcs_vld_o, done_o, crc_err_o, drop_o;
  logic [15:0] crc_status_o;

  int n_chk, n_bad;
  logic [15:0] last_tx;

  hdr_crc16 u_hdr_crc16 (
    .clk (clk), .rst_n (rst_n), .start_i (start_i), .dir_tx_i (dir_tx_i),
    .drop_on_err_i (drop_on_err_i), .bit_vld_i (bit_vld_i), .bit_i (bit_i),
    .fcs_phase_i (fcs_phase_i), .fcs_bit_o (fcs_bit_o), .fcs_vld_o (fcs_vld_o),
    .crc_status_o (crc_status_o), .done_o (done_o), .crc_err_o (crc_err_o),
    .drop_o (drop_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [15:0] model_fcs(input logic [71:0] data, input int n);
    logic [15:0] r = 16'hFFFF;
    for (int i = n - 1; i >= 0; i--) begin
      logic fb = r[15] ^ data[i];
      r = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h1021;
    end
    return ~r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic s, input logic v, input logic b, input logic f);
    @(negedge clk);
    start_i = s; bit_vld_i = v; bit_i = b; fcs_phase_i = f;
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic send_hdr(input logic [71:0] data, input int n, input logic gaps);
    for (int i = n - 1; i >= 0; i--) begin
      drive(1'b0, 1'b1, data[i], 1'b0);
      if (gaps && (i % 3 == 0)) idle();   // R10 idle gaps
    end
  endtask

  task automatic tx_fcs(input logic [15:0] exp, input string req);
    for (int k = 15; k >= 0; k--) begin
      drive(1'b0, 1'b1, 1'b0, 1'b1);
      #1;
      check({req, " fcs bit"}, {31'd0, fcs_bit_o}, {31'd0, exp[k]});
      if (k == 15 || k == 0) check("R3 fcs_vld", {31'd0, fcs_vld_o}, 32'd1);
    end
  endtask

  initial begin
    n_chk = 0; n_bad = 0;
    #1000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] e;
    rst_n = 1'b0; start_i = 0; dir_tx_i = 1; drop_on_err_i = 0;
    bit_vld_i = 0; bit_i = 0; fcs_phase_i = 0;
    last_tx = 16'h0000;
    repeat (3) @(negedge clk);
    #1;
    check("R1 done in reset", {31'd0, done_o}, 32'd0);
    check("R1 status in reset", {16'd0, crc_status_o}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    idle(); #1;
    check("R1 flags after reset", {28'd0, done_o, crc_err_o, drop_o, fcs_vld_o}, 32'd0);
    check("R1 status after reset", {16'd0, crc_status_o}, 32'd0);

    // Vector walk
    for (int v = 0; v < NV; v++) begin
      vec_t t = VECS[v];
      e = model_fcs({24'd0, t.hdr}, int'(t.nbits));
      dir_tx_i = t.tx; drop_on_err_i = t.drop_en;
      drive(1'b1, 1'b0, 1'b0, 1'b0);
      send_hdr({24'd0, t.hdr}, int'(t.nbits), t.gaps);
      if (t.tx) begin
        tx_fcs(e, "R3");
        last_tx = e;
      end else begin
        for (int k = 15; k >= 0; k--) drive(1'b0, 1'b1, e[k] ^ t.flip[k], 1'b1);
      end
      idle(); #1;
      check("R6 done after 16th bit", {31'd0, done_o}, 32'd1);
      check("R5 crc_err", {31'd0, crc_err_o}, {31'd0, (t.flip != 0) & ~t.tx});
      check("R7 drop", {31'd0, drop_o}, {31'd0, (t.flip != 0) & ~t.tx & t.drop_en});
      check("R4 status", {16'd0, crc_status_o}, {16'd0, last_tx});
      idle(); #1;
      check("R6 done single pulse", {31'd0, done_o}, 32'd0);
    end

    // R2 known value
    dir_tx_i = 1; drop_on_err_i = 0;
    drive(1'b1, 1'b0, 1'b0, 1'b0);
    send_hdr(72'h31_32_33_34_35_36_37_38_39, 72, 1'b0);
    tx_fcs(16'hD64E, "R2");
    idle(); #1;
    check("R2 status 123456789", {16'd0, crc_status_o}, 32'h0000_D64E);

    // R8 extra bits after completion are ignored
    for (int k = 0; k < 4; k++) begin
      drive(1'b0, 1'b1, 1'b1, 1'b1); #1;
      check("R8 fcs_vld stays low", {31'd0, fcs_vld_o}, 32'd0);
    end
    idle(); #1;
    check("R8 no second done", {31'd0, done_o}, 32'd0);
    check("R8 status kept", {16'd0, crc_status_o}, 32'h0000_D64E);

    // R9 start colliding with the 16th checksum bit
    e = model_fcs(72'hC3, 8);
    drive(1'b1, 1'b0, 1'b0, 1'b0);
    send_hdr(72'hC3, 8, 1'b0);
    for (int k = 0; k < 15; k++) drive(1'b0, 1'b1, 1'b0, 1'b1);
    drive(1'b1, 1'b1, 1'b0, 1'b1);
    idle(); #1;
    check("R9 no done on collision", {31'd0, done_o}, 32'd0);
    check("R9 status from collided frame", {16'd0, crc_status_o}, {16'd0, e});
    send_hdr(72'h31_32_33_34_35_36_37_38_39, 72, 1'b0);
    tx_fcs(16'hD64E, "R9");
    idle(); #1;
    check("R9 fresh frame done", {31'd0, done_o}, 32'd1);
    check("R9 fresh frame status", {16'd0, crc_status_o}, 32'h0000_D64E);

    idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule